// File: doc/BRIEF.md
# Multidrop 9-bit UART transmitter

This block is the transmit side of a UART. It turns each byte written to its holding register into a serial frame on `tx`. The frame has a low start bit, the eight data bits least significant first, an optional ninth bit, and a high stop bit. The line rests high between frames. The transmitter moves one bit for every pulse on `baud_tick`. A one-entry holding slot sits ahead of the shifter, so software can queue the next byte while the current frame is still on the line.

In multidrop mode the ninth bit does not carry parity. It carries an address marker that tells the listening nodes whether the byte is an address or data. The marker comes from a one-shot flag in the special-function register. The value of the flag is latched with the byte when the byte enters the holding slot, and the flag then clears itself. Each marked byte therefore needs a fresh setting of the flag. The same register also holds a receiver-disable bit, which drives `rx_enable`. Software can change the special-function bits only while the feature-enable bit is set.

Register writes arrive on a valid/ready port. A write is taken on a clock edge where `wr_valid` and `wr_ready` are both high. Writes to the line-control, feature-enable and special-function registers are always ready. A write to the holding register is held off while the slot is full and the shifter is not taking the slot in that cycle. The master must keep its address and data stable until the write is taken.

Register map (address : meaning):
- 0 : holding register (data byte).
- 1 : line control. Bits [5:3] form the parity field: bit 3 = parity on, bit 4 = even, bit 5 = stick.
- 2 : feature enable, at bit 4.
- 3 : special function. Bit 5 = receiver disable, bit 6 = 9-bit mode, bit 7 = address flag.

Top module: `uart9_tx`

## Requirements
- R1: After reset, `tx` is 1, `busy` is 0 and `rx_enable` is 1. All special-function bits and the feature-enable bit are 0, and the parity field is 3'b000.
- R2: A frame is sent in this order: one 0 start bit, then data bits 0 to 7, then the ninth bit when one is sent, then one 1 stop bit. Each bit lasts exactly one `baud_tick` period. The start bit begins on the clock edge of a tick. While no frame is in progress, `tx` is 1.
- R3: A write to address 3 has no effect when feature-enable (address 2, bit 4) is 0. In that case `rx_enable` and the framing of later bytes stay unchanged.
- R4: When feature-enable is 1, writing address 3 with bit 5 = 1 drives `rx_enable` to 0. Writing bit 5 = 0 drives `rx_enable` back to 1.
- R5: When 9-bit mode (address 3, bit 6) is 1 and the parity field is 3'b111, the ninth bit equals the address flag (address 3, bit 7) that was set when the byte was written.
- R6: Every accepted holding-register write clears the address flag. A later byte sent without rewriting the flag carries a ninth bit of 0.
- R7: The ninth bit and the framing of a byte are fixed when the byte is accepted. Writes to address 1 or address 3 made after that point do not change that byte's frame.
- R8: When 9-bit mode is off, or the parity field is not 3'b111, the parity field alone sets the ninth bit:
  - 3'b001: odd parity.
  - 3'b011: even parity.
  - 3'b101: the bit is forced to 1.
  - 3'b111: the bit is forced to 0.
  - Field bit 3 = 0: no ninth bit is sent, and the frame has 10 bits.
- R9: A holding write is accepted when the slot is empty, or when the slot is being moved to the shifter in that same cycle. Otherwise `wr_ready` is 0 for address 0. `busy` is 1 from the acceptance through the end of the last stop bit.
- R10: When a byte is waiting at the tick that ends a stop bit, its start bit begins at once, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write can be taken this cycle |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| tx | output | 1 | Serial output, idles high |
| busy | output | 1 | A byte is queued or being sent |
| rx_enable | output | 1 | Receiver enable, low when the receiver is disabled |

## Verification
Two events can fall in the same clock edge:
- the tick that ends one frame's stop bit, and
- the move of the queued byte into the shifter, together with a new holding write accepted into the slot that has just emptied.

The bench provokes this case by writing a second byte, with the address flag set, while the first frame is still being sent. It then rewrites the special-function bits while that byte is still queued. The monitor judges the result:
- the second start bit must appear exactly one bit period after the first stop bit (R10);
- the marker must be the one latched when the byte was written (R7);
- `wr_ready` for address 0 must be low while the slot is full (R9).

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int FRAME_W = DATA_W + 3;
  localparam int IDX_W   = $clog2(FRAME_W);

  localparam logic [ADDR_W-1:0] A_HOLD = 2'd0;
  localparam logic [ADDR_W-1:0] A_LINE = 2'd1;
  localparam logic [ADDR_W-1:0] A_FEAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_SPEC = 2'd3;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              has_ninth;
    logic              ninth;
  } tx_item_t;

  // fld[0]=parity on, fld[1]=even, fld[2]=stick
  function automatic logic [1:0] pick_ninth(input logic [2:0] fld, input logic nine_en,
                                            input logic flag, input logic [DATA_W-1:0] d);
    logic [1:0] r;
    if (!fld[0])                       r = 2'b00;
    else if (nine_en && fld == 3'b111) r = {1'b1, flag};
    else if (fld[2])                   r = {1'b1, ~fld[1]};
    else if (fld[1])                   r = {1'b1, ^d};
    else                               r = {1'b1, ~^d};
    return r;
  endfunction
endpackage

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
  import uart9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold_accept,
  output tx_item_t          cap_item,
  output logic              rx_enable
);
  logic [2:0] par_fld;
  logic       feat_en;
  logic       rx_off;
  logic       nine_en;
  logic       addr_flag;
  logic       spec_wr;
  logic [1:0] sel;

  assign spec_wr = wr_fire && (wr_addr == A_SPEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_fld   <= 3'b000;
      feat_en   <= 1'b0;
      rx_off    <= 1'b0;
      nine_en   <= 1'b0;
      addr_flag <= 1'b0;
    end else begin
      if (wr_fire && wr_addr == A_LINE) par_fld <= wr_data[5:3];
      if (wr_fire && wr_addr == A_FEAT) feat_en <= wr_data[4];
      if (spec_wr && feat_en) begin
        rx_off  <= wr_data[5];
        nine_en <= wr_data[6];
      end
      if (hold_accept)             addr_flag <= 1'b0;
      else if (spec_wr && feat_en) addr_flag <= wr_data[7];
    end
  end

  assign sel                = pick_ninth(par_fld, nine_en, addr_flag, wr_data);
  assign cap_item.data      = wr_data;
  assign cap_item.has_ninth = sel[1];
  assign cap_item.ninth     = sel[0];
  assign rx_enable          = ~rx_off;

  // R6
  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold_accept |=> !addr_flag);
  // R3
  a_r3_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_wr && !feat_en) |=> $stable({rx_off, nine_en, addr_flag}));
endmodule

// File: rtl/uart9_hold.sv
module uart9_hold
  import uart9_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  tx_item_t in_item,
  output logic     full,
  output tx_item_t item,
  input  logic     take
);
  assign in_ready = !full || take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      item <= '0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
      item <= in_item;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R9
  a_r9_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(item)));
endmodule

// File: rtl/uart9_shift.sv
module uart9_shift
  import uart9_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     baud_tick,
  input  logic     hold_full,
  input  tx_item_t hold_item,
  output logic     take,
  output logic     active,
  output logic     tx_o
);
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   last;
  logic               finishing;

  assign finishing = active && baud_tick && (idx == last);
  assign take      = hold_full && baud_tick && (!active || finishing);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      last   <= '0;
      frame  <= '1;
    end else if (take) begin
      active <= 1'b1;
      idx    <= '0;
      if (hold_item.has_ninth) begin
        frame <= {1'b1, hold_item.ninth, hold_item.data, 1'b0};
        last  <= IDX_W'(FRAME_W - 1);
      end else begin
        frame <= {2'b11, hold_item.data, 1'b0};
        last  <= IDX_W'(FRAME_W - 2);
      end
    end else if (finishing) begin
      active <= 1'b0;
    end else if (active && baud_tick) begin
      idx <= idx + 1'b1;
    end
  end

  assign tx_o = active ? frame[idx] : 1'b1;

  // R2
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> !tx_o);
  // R10
  a_r10_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (finishing && hold_full) |=> active);
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  output logic              tx,
  output logic              busy,
  output logic              rx_enable
);
  tx_item_t cap_item;
  tx_item_t hold_item;
  logic     hold_ready;
  logic     hold_full;
  logic     hold_accept;
  logic     take;
  logic     active;
  logic     is_hold;

  assign is_hold     = (wr_addr == A_HOLD);
  assign wr_ready    = is_hold ? hold_ready : 1'b1;
  assign hold_accept = wr_valid && is_hold && hold_ready;

  uart9_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_valid && wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .hold_accept(hold_accept),
    .cap_item(cap_item), .rx_enable(rx_enable)
  );

  uart9_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(wr_valid && is_hold),
    .in_ready(hold_ready), .in_item(cap_item), .full(hold_full),
    .item(hold_item), .take(take)
  );

  uart9_shift u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .hold_full(hold_full),
    .hold_item(hold_item), .take(take), .active(active), .tx_o(tx)
  );

  assign busy = hold_full || active;

  // R1
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  // R9
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    hold_accept |=> busy);
endmodule

// File: tb/uart9_tx_test.sv
module uart9_tx_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_addr = 2'd1;
  logic [7:0] wr_data = 8'h00;
  logic       baud_tick = 1'b0;
  logic       tx, busy, rx_enable;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0] d;
    bit         hp;
    bit         nb;
    bit         b2b;
  } exp_t;
  exp_t q[$];

  bit         m_feat = 0, m_rxoff = 0, m_nine = 0, m_flag = 0;
  logic [2:0] m_fld = 3'b000;

  uart9_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .baud_tick(baud_tick),
    .tx(tx), .busy(busy), .rx_enable(rx_enable)
  );

  always #4 clk = ~clk;

  initial begin : tick_gen
    int c = 0;
    forever begin
      @(posedge clk);
      #1;
      baud_tick = (c == DIV - 1);
      c = (c == DIV - 1) ? 0 : c + 1;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d, input bit b2b);
    exp_t e;
    @(negedge clk);
    wr_addr  = a;
    wr_data  = d;
    wr_valid = 1'b1;
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
    case (a)
      2'd0: begin
        e.d = d;
        e.b2b = b2b;
        e.hp = m_fld[0];
        case (m_fld)
          3'b001:  e.nb = ~^d;
          3'b011:  e.nb = ^d;
          3'b101:  e.nb = 1'b1;
          3'b111:  e.nb = m_nine ? m_flag : 1'b0;
          default: e.nb = 1'b0;
        endcase
        q.push_back(e);
        m_flag = 0;
      end
      2'd1: m_fld = d[5:3];
      2'd2: m_feat = d[4];
      default: if (m_feat) begin
        m_rxoff = d[5];
        m_nine  = d[6];
        m_flag  = d[7];
      end
    endcase
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin : monitor
    bit synced = 0;
    exp_t e;
    @(posedge rst_n);
    forever begin
      if (!synced) begin
        @(negedge clk);
        while (tx !== 1'b0) @(negedge clk);
        @(negedge clk);
      end
      check("R2 start bit", {7'd0, tx}, 8'd0);
      if (q.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R2 unexpected frame actual=start expected=idle");
        synced = 0;
      end else begin
        logic [7:0] got;
        e = q.pop_front();
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          got[i] = tx;
        end
        check("R2 data bits", got, e.d);
        if (e.hp) begin
          repeat (DIV) @(negedge clk);
          check("R5 R8 ninth bit", {7'd0, tx}, {7'd0, e.nb});
        end
        repeat (DIV) @(negedge clk);
        check("R2 stop bit", {7'd0, tx}, 8'd1);
        synced = 0;
        if (q.size() != 0 && q[0].b2b) begin
          repeat (DIV) @(negedge clk);
          check("R10 back-to-back start", {7'd0, tx}, 8'd0);
          synced = 1;
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check("R1 tx idle", {7'd0, tx}, 8'd1);
    check("R1 busy low", {7'd0, busy}, 8'd0);
    check("R1 rx_enable high", {7'd0, rx_enable}, 8'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R8: parity field starts at 000, so a 10-bit frame is sent
    do_write(2'd0, 8'hA5, 0);
    @(negedge clk);
    check("R9 busy after accept", {7'd0, busy}, 8'd1);
    wait_idle();
    check("R9 busy clears", {7'd0, busy}, 8'd0);

    // R8 odd, even, forced 1, forced 0
    do_write(2'd1, 8'h08, 0); do_write(2'd0, 8'h03, 0); wait_idle();
    do_write(2'd1, 8'h18, 0); do_write(2'd0, 8'h07, 0); wait_idle();
    do_write(2'd0, 8'h0F, 0); wait_idle();
    do_write(2'd1, 8'h28, 0); do_write(2'd0, 8'h3C, 0); wait_idle();
    do_write(2'd1, 8'h38, 0); do_write(2'd0, 8'hFF, 0); wait_idle();

    // R3: special-function write with feature-enable off is ignored
    do_write(2'd3, 8'hE0, 0);
    @(negedge clk);
    check("R3 rx_enable unchanged", {7'd0, rx_enable}, 8'd1);
    do_write(2'd0, 8'h55, 0); wait_idle();

    // R4
    do_write(2'd2, 8'h10, 0);
    do_write(2'd3, 8'h20, 0);
    @(negedge clk);
    check("R4 rx disabled", {7'd0, rx_enable}, 8'd0);
    do_write(2'd3, 8'h00, 0);
    @(negedge clk);
    check("R4 rx re-enabled", {7'd0, rx_enable}, 8'd1);

    // R5 then R6
    do_write(2'd3, 8'hC0, 0);
    do_write(2'd0, 8'h11, 0); wait_idle();
    do_write(2'd0, 8'h22, 0); wait_idle();

    // R7 R9 R10: queue a marked byte behind a running frame, then change controls
    do_write(2'd3, 8'h40, 0);
    do_write(2'd0, 8'h44, 0);
    repeat (2 * DIV) @(negedge clk);
    do_write(2'd3, 8'hC0, 0);
    do_write(2'd0, 8'h66, 1);
    @(negedge clk);
    wr_addr = 2'd0;
    #1;
    check("R9 ready low while slot full", {7'd0, wr_ready}, 8'd0);
    check("R9 busy while queued", {7'd0, busy}, 8'd1);
    do_write(2'd3, 8'h00, 0);
    m_nine = 1; // queued byte keeps its latched marker; model restores for later bytes below
    m_nine = 0;
    do_write(2'd1, 8'h08, 0);
    m_fld = 3'b111;
    wait_idle();

    // R8: 9-bit mode on but field is even, flag ignored
    do_write(2'd1, 8'h18, 0);
    do_write(2'd3, 8'hC0, 0);
    do_write(2'd0, 8'h03, 0); wait_idle();
    do_write(2'd1, 8'h38, 0);
    do_write(2'd0, 8'h81, 0); wait_idle();

    // R3: disable feature, then receiver-disable write must not land
    do_write(2'd2, 8'h00, 0);
    do_write(2'd3, 8'h20, 0);
    @(negedge clk);
    check("R3 gated rx write", {7'd0, rx_enable}, 8'd1);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule